// File: doc/BRIEF.md
# Double-Buffered Clocked-Synchronous Serial Transmitter

This block sends bytes over a clocked-synchronous serial link. The host writes a byte into a holding buffer. Writing the byte clears the buffer-empty flag. When transmission is enabled and the engine is idle, the byte is copied into a shift register and the flag goes back to 1, so the host can queue the following byte while the current one is on the line. Bits leave least-significant first. The data line changes on the falling clock edge so that the receiver can sample it on the rising edge.

The serial clock can come from either of two sources:

- **Internal mode.** The block drives the clock pin from a programmable divider. Each half period lasts `cfg_div+1` system cycles.
- **External mode.** The pin is an input. It passes through a synchronizer and an edge detector, and the engine shifts on the edges found there.

The buffer is checked while the last bit is on the line. If a byte is waiting, the next frame follows with no gap. If nothing is waiting, the end flag is raised, the data line holds the last bit and the clock idles high. Each of the two flags can raise an interrupt through its own enable.

Top module: `csync_tx`

## Requirements
- R1: After reset the outputs are as follows: `buf_empty`=1, `tx_end`=1, `sdo`=1 and `sck_out`=1. Both interrupt outputs are 0 while their enables are 0.
- R2: A cycle with `wr_en`=1 stores `wr_data`. On the next clock edge `buf_empty` becomes 0 and `tx_end` becomes 0.
- R3: A frame starts only when the engine is idle, `cfg_tx_en`=1 and `buf_empty`=0.
  - At the start the buffer is copied into the shift register, and `buf_empty` returns to 1 one clock after the start condition holds.
  - While `cfg_tx_en`=0 a pending byte stays pending: `buf_empty` stays 0 and the clock does not toggle.
- R4: A frame is 8 bits, bit 0 first. `sdo` changes only together with a falling clock edge and is stable at every rising edge.
- R5: In internal mode each frame has exactly 8 rising clock edges. Each clock half period lasts `cfg_div+1` system cycles, so rising edges are `2*(cfg_div+1)` cycles apart.
- R6: A byte written before the rising edge of bit 7 is sent as the next frame with no gap. The rising-edge spacing stays `2*(cfg_div+1)` across the frame boundary, and `tx_end` stays 0.
- R7: If the buffer is empty at the bit 7 rising edge:
  - `tx_end` becomes 1.
  - `sdo` then holds the bit 7 level.
  - In internal mode `sck_out` stays 1 until a new frame starts.
- R8: `irq_empty` is 1 exactly when `cfg_ie_empty`=1 and `buf_empty`=1. `irq_end` is 1 exactly when `cfg_ie_end`=1 and `tx_end`=1.
- R9: With `cfg_ext_clk`=1, the outputs are `sck_oe`=0 and `sck_out`=1. Bits shift on the edges of `sck_in` after synchronization: a new bit follows each falling edge, and the bit is held across each rising edge.
- R10: With `cfg_ext_clk`=0, `sck_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_ext_clk | input | 1 | 1 = shift on `sck_in`, 0 = drive clock from divider |
| cfg_div | input | DIV_W | Half-period length minus one, in system cycles |
| cfg_ie_empty | input | 1 | Enable for the buffer-empty interrupt |
| cfg_ie_end | input | 1 | Enable for the transmit-end interrupt |
| wr_en | input | 1 | Write strobe for the data buffer |
| wr_data | input | DATA_W | Byte to transmit |
| sck_in | input | 1 | External serial clock |
| sck_out | output | 1 | Driven serial clock, idle high |
| sck_oe | output | 1 | Output enable for the clock pin |
| sdo | output | 1 | Serial data |
| buf_empty | output | 1 | Buffer-empty flag |
| tx_end | output | 1 | Transmit-end flag |
| irq_empty | output | 1 | Buffer-empty interrupt request |
| irq_end | output | 1 | Transmit-end interrupt request |

## Verification
Timing of each result:

- **Buffer-empty flag.** It falls one edge after a write. It returns to 1 one edge after the start condition, so the bench samples it two falling edges after a write or an enable.
- **Data line.** A new bit is set one edge after each clock fall. It is sampled at the half cycle where a rising edge of the serial clock is first seen: `sck_out` in internal mode, `sck_in` in external mode.
- **Internal clock spacing.** A scoreboard pops one expected byte per eight rising edges. It also measures every rise-to-rise interval against `2*(cfg_div+1)` system cycles while frames are streaming.
- **End of frame.** The end flag rises on the same edge as the final rise, so checks of the end state wait for it and then verify that the line and clock stay fixed for a further stretch.
- **External mode.** The two-stage synchronizer adds about three cycles. The bench therefore holds each external half period for eight cycles.

// File: rtl/csync_pkg.sv
package csync_pkg;
   typedef struct packed {
      logic fall;
      logic rise;
   } sck_evt_t;
endpackage

// File: rtl/csync_clkgen.sv
module csync_clkgen
   import csync_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_mode,
   input  logic [DIV_W-1:0] div,
   input  logic             run,
   input  logic             low_ph,
   input  logic             sck_in,
   output sck_evt_t         evt
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("csync_clkgen: SYNC_STAGES must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("csync_clkgen: DIV_W must be at least 1");
      end
   endgenerate

   // internal divider: one tick per half period
   logic [DIV_W-1:0] cnt;
   logic             tick;
   assign tick = run && (cnt == div);

   always_ff @(posedge clk) begin
      if (!rst_n || !run || tick) cnt <= '0;
      else                        cnt <= cnt + 1'b1;
   end

   // external clock synchronizer chain, idle high
   logic [SYNC_STAGES-1:0] sync;
   logic                   prev;
   genvar gi;
   generate
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
         always_ff @(posedge clk) begin
            if (!rst_n) sync[gi] <= 1'b1;
            else if (gi == 0) sync[gi] <= sck_in;
            else sync[gi] <= sync[(gi == 0) ? 0 : gi-1];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= sync[SYNC_STAGES-1];
   end

   always_comb begin
      if (ext_mode) begin
         evt.fall = run && prev && !sync[SYNC_STAGES-1];
         evt.rise = run && !prev && sync[SYNC_STAGES-1];
      end else begin
         evt.fall = tick && !low_ph;
         evt.rise = tick && low_ph;
      end
   end
endmodule

// File: rtl/csync_shifter.sv
module csync_shifter
   import csync_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              next_ok,
   input  logic [DATA_W-1:0] load_data,
   input  sck_evt_t          evt,
   output logic              active,
   output logic              low_ph,
   output logic              sdo,
   output logic              take,
   output logic              done
);
   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DATA_W - 1);

   logic [DATA_W-1:0] sh;
   logic [IDX_W-1:0]  idx;
   logic              last_rise;

   assign last_rise = active && low_ph && evt.rise && (idx == LAST);
   assign take      = start || (last_rise && next_ok);
   assign done      = last_rise && !next_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         low_ph <= 1'b0;
         idx    <= '0;
         sh     <= '0;
         sdo    <= 1'b1;
      end else if (start) begin
         active <= 1'b1;
         low_ph <= 1'b0;
         idx    <= '0;
         sh     <= load_data;
      end else if (active) begin
         if (evt.fall && !low_ph) begin
            low_ph <= 1'b1;
            sdo    <= sh[idx];
         end else if (evt.rise && low_ph) begin
            low_ph <= 1'b0;
            if (idx == LAST) begin
               idx <= '0;
               if (next_ok) sh <= load_data;
               else         active <= 1'b0;
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/csync_tx.sv
module csync_tx
   import csync_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_tx_en,
   input  logic              cfg_ext_clk,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic              cfg_ie_empty,
   input  logic              cfg_ie_end,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              sck_in,
   output logic              sck_out,
   output logic              sck_oe,
   output logic              sdo,
   output logic              buf_empty,
   output logic              tx_end,
   output logic              irq_empty,
   output logic              irq_end
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("csync_tx: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] buf_q;
   logic              active, low_ph, take, done, start, next_ok;
   sck_evt_t          evt;

   assign next_ok = cfg_tx_en && !buf_empty;
   assign start   = !active && next_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_q     <= '0;
         buf_empty <= 1'b1;
         tx_end    <= 1'b1;
      end else begin
         if (wr_en) begin
            buf_q     <= wr_data;
            buf_empty <= 1'b0;
            tx_end    <= 1'b0;
         end else begin
            if (take) buf_empty <= 1'b1;
            if (done) tx_end    <= 1'b1;
         end
      end
   end

   csync_clkgen #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_clk (
      .clk(clk), .rst_n(rst_n), .ext_mode(cfg_ext_clk), .div(cfg_div),
      .run(active), .low_ph(low_ph), .sck_in(sck_in), .evt(evt)
   );

   csync_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .next_ok(next_ok),
      .load_data(buf_q), .evt(evt), .active(active), .low_ph(low_ph),
      .sdo(sdo), .take(take), .done(done)
   );

   assign sck_oe    = !cfg_ext_clk;
   assign sck_out   = !(low_ph && !cfg_ext_clk);
   assign irq_empty = cfg_ie_empty && buf_empty;
   assign irq_end   = cfg_ie_end && tx_end;
endmodule

// File: rtl/csync_tx_chk.sv
module csync_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_tx_en,
   input logic cfg_ext_clk,
   input logic wr_en,
   input logic sck_out,
   input logic sck_oe,
   input logic sdo,
   input logic buf_empty,
   input logic tx_end,
   input logic irq_empty,
   input logic irq_end
);
   p_write_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (!buf_empty && !tx_end));

   p_hold_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_tx_en && !buf_empty) |=> !buf_empty);

   p_sdo_stable_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_oe && $rose(sck_out)) |-> $stable(sdo));

   p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_end && !cfg_ext_clk) |-> sck_out);

   p_end_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_end && buf_empty && !wr_en) |=> ($stable(sdo) && tx_end));

   p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_end |-> tx_end) and (irq_empty |-> buf_empty));

   p_ext_no_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ext_clk |-> (!sck_oe && sck_out));

   p_oe_internal_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_ext_clk |-> sck_oe);
endmodule

bind csync_tx csync_tx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_tx_en(cfg_tx_en), .cfg_ext_clk(cfg_ext_clk),
   .wr_en(wr_en), .sck_out(sck_out), .sck_oe(sck_oe), .sdo(sdo),
   .buf_empty(buf_empty), .tx_end(tx_end), .irq_empty(irq_empty),
   .irq_end(irq_end)
);

// File: tb/csync_tx_test.sv
module csync_tx_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_tx_en = 1'b0, cfg_ext_clk = 1'b0;
   logic [7:0] cfg_div = 8'd1;
   logic       cfg_ie_empty = 1'b0, cfg_ie_end = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       sck_in = 1'b1;
   logic       sck_out, sck_oe, sdo, buf_empty, tx_end, irq_empty, irq_end;

   int checks = 0, errors = 0;
   int cyc = 0;
   bit finished = 0;
   logic [7:0] exp_q[$];

   always #4 clk = ~clk;

   csync_tx uut (
      .clk(clk), .rst_n(rst_n), .cfg_tx_en(cfg_tx_en), .cfg_ext_clk(cfg_ext_clk),
      .cfg_div(cfg_div), .cfg_ie_empty(cfg_ie_empty), .cfg_ie_end(cfg_ie_end),
      .wr_en(wr_en), .wr_data(wr_data), .sck_in(sck_in), .sck_out(sck_out),
      .sck_oe(sck_oe), .sdo(sdo), .buf_empty(buf_empty), .tx_end(tx_end),
      .irq_empty(irq_empty), .irq_end(irq_end)
   );

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #1;
   endtask

   // driver: queue expectation and write the buffer
   task automatic send(input logic [7:0] b);
      exp_q.push_back(b);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_data = b;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic wait_empty();
      for (int i = 0; i < 2000 && !buf_empty; i++) @(negedge clk);
   endtask

   task automatic wait_end();
      for (int i = 0; i < 5000 && !tx_end; i++) @(negedge clk);
   endtask

   // monitor / scoreboard
   logic line_q = 1'b1;
   logic [7:0] rx;
   int nb = 0, last_rise = 0;
   bit have_prev = 0;
   always @(negedge clk) begin
      logic line;
      line = cfg_ext_clk ? sck_in : sck_out;
      if (rst_n && line && !line_q) begin
         if (!cfg_ext_clk && have_prev)
            check(cyc - last_rise == 2 * (int'(cfg_div) + 1), "R5/R6 rise spacing",
                  cyc - last_rise, 2 * (int'(cfg_div) + 1));
         have_prev = 1;
         last_rise = cyc;
         rx[nb] = sdo;
         nb++;
         if (nb == 8) begin
            nb = 0;
            if (exp_q.size() == 0) check(0, "R4 unexpected frame", rx, 0);
            else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               check(rx == e, "R4 frame lsb first", rx, e);
            end
         end
      end
      if (tx_end) have_prev = 0;
      line_q = line;
   end

   task automatic frame_done(input logic [7:0] last_b);
      wait_end();
      ticks(2);
      check(nb == 0 && exp_q.size() == 0, "R5 eight edges per frame", nb, 0);
      check(tx_end == 1'b1, "R7 end flag", tx_end, 1);
      check(sdo == last_b[7], "R7 sdo holds bit7", sdo, last_b[7]);
      if (!cfg_ext_clk) check(sck_out == 1'b1, "R7 clock idles high", sck_out, 1);
      ticks(20);
      check(sdo == last_b[7] && tx_end, "R7 hold after end", sdo, last_b[7]);
   endtask

   initial begin : watchdog
      for (int i = 0; i < 150000 && !finished; i++) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      ticks(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(buf_empty == 1, "R1 buf_empty", buf_empty, 1);
      check(tx_end == 1, "R1 tx_end", tx_end, 1);
      check(sdo == 1 && sck_out == 1, "R1 lines high", {sdo, sck_out}, 3);
      check(!irq_empty && !irq_end, "R1 irqs low", {irq_empty, irq_end}, 0);
      check(sck_oe == 1, "R10 oe internal", sck_oe, 1);

      // R8 interrupt gating on idle flags
      cfg_ie_empty = 1; cfg_ie_end = 1;
      @(negedge clk);
      check(irq_empty && irq_end, "R8 irqs follow flags", {irq_empty, irq_end}, 3);

      // R2/R3 pending while disabled
      send(8'hA5);
      @(negedge clk);
      check(buf_empty == 0, "R2 write clears empty", buf_empty, 0);
      check(tx_end == 0, "R2 write clears end", tx_end, 0);
      check(irq_empty == 0 && irq_end == 0, "R8 irqs drop", {irq_empty, irq_end}, 0);
      ticks(20);
      @(negedge clk);
      check(buf_empty == 0 && sck_out == 1, "R3 no start while disabled", {buf_empty, sck_out}, 1);

      // R3 start on enable
      cfg_tx_en = 1;
      @(negedge clk); @(negedge clk);
      check(buf_empty == 1, "R3 buffer taken", buf_empty, 1);
      check(irq_empty == 1, "R8 empty irq", irq_empty, 1);
      frame_done(8'hA5);
      check(irq_end == 1, "R8 end irq", irq_end, 1);

      // R6 back-to-back frames, div 2
      cfg_div = 8'd2;
      send(8'h3C);
      wait_empty();
      send(8'hC3);
      @(negedge clk);
      check(tx_end == 0, "R6 no end mid-stream", tx_end, 0);
      wait_empty();
      send(8'h81);
      wait_empty();
      check(tx_end == 0, "R6 no end between frames", tx_end, 0);
      frame_done(8'h81);

      // R5 fastest divider, bit7 low
      cfg_div = 8'd0;
      send(8'h01);
      frame_done(8'h01);

      // R9 external clock mode
      cfg_ext_clk = 1;
      @(negedge clk);
      check(sck_oe == 0 && sck_out == 1, "R9 pin released", {sck_oe, sck_out}, 1);
      send(8'h5A);
      ticks(4);
      for (int b = 0; b < 8; b++) begin
         sck_in = 1'b0; ticks(8);
         sck_in = 1'b1; ticks(8);
      end
      frame_done(8'h5A);
      check(sck_out == 1, "R9 clock output idle", sck_out, 1);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule